// File: doc/BRIEF.md
# Receive Buffer-Descriptor Scatter Engine

This block takes one received frame at a time from a byte stream and spreads it over a ring of receive buffer descriptors in shared memory. It adds a CRC-32 of the frame as four trailing bytes. Each descriptor buffer takes at most a software-set number of bytes. When a buffer is filled, the block writes the byte count and status flags back into that descriptor and clears its empty flag. It also records a buffer event, or a frame event for the last buffer. After each frame it reads the next descriptor and stays ready for another frame only if that descriptor is empty.

A descriptor is two 32-bit words at an 8-byte-aligned address. Word 0 (offset 0) holds the flags in bits 31:16 and the byte count in bits 15:0. Word 1 (offset 4) holds the buffer's byte address. The memory port is byte addressed with 32-bit data and byte strobes, and read data arrives one cycle after the request. The register bus is a word-indexed write strobe with a combinational read mux. Register indices are: 0 events, 1 event mask, 2 arm/active, 3 receive control, 4 ring start, 5 buffer size.

Top module: `rx_bd_scatter`

## Requirements
- R1: The stored size is the frame length plus 4. If that exceeds `MAX_FRAME`, only the first `MAX_FRAME`-4 frame bytes are stored, followed by the CRC of the whole frame. The last descriptor then carries the truncated flag (word 0 bit 16) and the length-error flag (word 0 bit 21).
- R2: The length-error flag is also set when the stored size exceeds bits 31:16 of the receive control register (index 3). That register resets to 0x05EE0001 and keeps only the written bits in mask 0x07FF003F.
- R3: Each descriptor takes min(bytes still to store, buffer size) bytes, and that count goes into word 0 bits 15:0. The buffer size register (index 5) keeps only bits 13:4 of a write, and resets to 0.
- R4: The CRC is the reflected CRC-32 (polynomial 0xEDB88320, preset all ones, inverted at the end). It is stored after the data, most significant byte first, and may continue from one buffer into the next.
- R5: Each filled descriptor has its empty flag (word 0 bit 31) cleared and its other flags kept. Only the last one gains the last flag (bit 27) and the error flags. The last one sets event bit 0; every other filled descriptor sets event bit 1.
- R6: With the wrap flag (word 0 bit 29) set, the next descriptor is the ring start (index 4, low 3 bits dropped). Otherwise the next descriptor is 8 bytes on. Writing the ring start also moves the current descriptor there.
- R7: If a descriptor needed for a frame is not empty, nothing more of that frame is stored. The rest of the frame is consumed and discarded, and no descriptor gets the last flag.
- R8: After each frame, the active flag (index 2 bit 0) is reloaded from the empty flag of the current descriptor. A write to index 2 while inactive triggers the same probe. While inactive, `in_ready` stays low.
- R9: Writing 1 to an event bit clears it, and writing 0 leaves it unchanged. `irq` is high whenever an event bit and its mask bit (index 1) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Final byte of frame |
| in_ready | output | 1 | Byte accepted this cycle |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write (1) or read (0) |
| mem_addr | output | AW | Byte address |
| mem_be | output | 4 | Byte lane strobes |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after request |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench builds the block with a 12-bit address space and `MAX_FRAME` set to 64. At that size truncation is reached with a 70-byte frame, so the hard-limit flags, the clipped data and the CRC over discarded bytes are all checked in a short run. Buffer sizes of 16 and 32 bytes put frame boundaries, CRC straddling, exact fits, ring wrap and the mid-frame drop within a four-descriptor ring.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int LW = 14;

    typedef enum logic [3:0] {
        S_IDLE, S_RD0, S_RD1, S_RD2, S_FILL, S_WB, S_DRAIN, S_PRB0, S_PRB1
    } st_e;

    localparam logic [2:0] RG_EVT  = 3'd0;
    localparam logic [2:0] RG_MASK = 3'd1;
    localparam logic [2:0] RG_ARM  = 3'd2;
    localparam logic [2:0] RG_RCTL = 3'd3;
    localparam logic [2:0] RG_RING = 3'd4;
    localparam logic [2:0] RG_MAXB = 3'd5;

    localparam int F_EMPTY = 31;
    localparam int F_WRAP  = 29;
    localparam int F_LAST  = 27;
    localparam int F_LGERR = 21;
    localparam int F_TRUNC = 16;

    localparam logic [31:0] RCTL_RST  = 32'h05EE_0001;
    localparam logic [31:0] RCTL_MASK = 32'h07FF_003F;
    localparam logic [31:0] MAXB_MASK = 32'h0000_3FF0;

    typedef struct packed {
        logic buffer;
        logic frame;
    } evt_t;

    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        end
        return r;
    endfunction
endpackage

// File: rtl/rxs_crc32.sv
module rxs_crc32 import rxs_pkg::*; (
    input  logic        clk,
    input  logic        init,
    input  logic        en,
    input  logic [7:0]  data,
    output logic [31:0] crc_nx
);
    logic [31:0] crc_q;

    assign crc_nx = crc_step(crc_q, data);

    always_ff @(posedge clk) begin
        if (init)    crc_q <= '1;
        else if (en) crc_q <= crc_nx;
    end
endmodule

// File: rtl/rxs_regfile.sv
module rxs_regfile import rxs_pkg::*; #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  evt_t          evt_set,
    input  logic          active,
    output evt_t          events,
    output logic          irq,
    output logic [LW-1:0] mrbr,
    output logic [15:0]   ulimit,
    output logic [AW-1:0] ring_base,
    output logic          ring_wr,
    output logic          arm_wr
);
    logic [1:0]  mask;
    logic [31:0] rctl;
    logic [31:0] maxb;

    assign ring_wr = reg_wr && (reg_addr == RG_RING);
    assign arm_wr  = reg_wr && (reg_addr == RG_ARM);
    assign mrbr    = maxb[LW-1:0];
    assign ulimit  = rctl[31:16];
    assign irq     = |(events & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            events    <= '0;
            mask      <= '0;
            rctl      <= RCTL_RST;
            maxb      <= '0;
            ring_base <= '0;
        end else begin
            events <= (reg_wr && reg_addr == RG_EVT) ? ((events & ~reg_wdata[1:0]) | evt_set)
                                                     : (events | evt_set);
            if (reg_wr) begin
                case (reg_addr)
                    RG_MASK: mask      <= reg_wdata[1:0];
                    RG_RCTL: rctl      <= reg_wdata & RCTL_MASK;
                    RG_MAXB: maxb      <= reg_wdata & MAXB_MASK;
                    RG_RING: ring_base <= {reg_wdata[AW-1:3], 3'b000};
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (reg_addr)
            RG_EVT:  reg_rdata = {30'h0, events};
            RG_MASK: reg_rdata = {30'h0, mask};
            RG_ARM:  reg_rdata = {31'h0, active};
            RG_RCTL: reg_rdata = rctl;
            RG_RING: reg_rdata = 32'(ring_base);
            RG_MAXB: reg_rdata = maxb;
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/rx_bd_scatter.sv
module rx_bd_scatter import rxs_pkg::*; #(
    parameter int AW        = 16,
    parameter int MAX_FRAME = 2032
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_last,
    output logic          in_ready,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [3:0]    mem_be,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          irq
);
    localparam logic [LW-1:0] DATA_LIM = LW'(MAX_FRAME - 4);

    st_e           st;
    logic          active, probe_pend, phase_crc, wb_last, trunc;
    logic [AW-1:0] cur, buf_base, byte_addr;
    logic [31:0]   desc_w0, crc_fin, crc_nx, wb_word;
    logic [1:0]    crc_idx;
    logic [7:0]    crc_byte;
    logic [LW-1:0] buf_cnt, data_cnt, tot_cnt, mrbr;
    logic [15:0]   ulimit;
    logic [AW-1:0] ring_base;
    logic          ring_wr, arm_wr, crc_en, store_ok, buf_full;
    evt_t          evt_set, events;

    rxs_regfile #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
        .active(active), .events(events), .irq(irq), .mrbr(mrbr),
        .ulimit(ulimit), .ring_base(ring_base), .ring_wr(ring_wr), .arm_wr(arm_wr)
    );

    rxs_crc32 u_crc (
        .clk(clk), .init(st == S_IDLE), .en(crc_en), .data(in_data), .crc_nx(crc_nx)
    );

    assign store_ok  = data_cnt < DATA_LIM;
    assign buf_full  = buf_cnt == mrbr;
    assign byte_addr = buf_base + AW'(buf_cnt);
    assign crc_byte  = 8'(crc_fin >> {2'd3 - crc_idx, 3'b000});

    always_comb begin
        wb_word = {desc_w0[31:16], 16'(buf_cnt)};
        wb_word[F_EMPTY] = 1'b0;
        if (wb_last) begin
            wb_word[F_LAST] = 1'b1;
            if (trunc) begin
                wb_word[F_TRUNC] = 1'b1;
                wb_word[F_LGERR] = 1'b1;
            end
            if (16'(tot_cnt) > ulimit) wb_word[F_LGERR] = 1'b1;
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cur;
        mem_be    = 4'hF;
        mem_wdata = '0;
        in_ready  = 1'b0;
        crc_en    = 1'b0;
        evt_set   = '0;
        case (st)
            S_RD0, S_PRB0: mem_req = 1'b1;
            S_RD1: begin
                mem_req  = 1'b1;
                mem_addr = cur + AW'(4);
            end
            S_FILL: begin
                if (phase_crc) begin
                    if (!buf_full) begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = byte_addr;
                        mem_be    = 4'b0001 << byte_addr[1:0];
                        mem_wdata = {4{crc_byte}};
                    end
                end else if (in_valid && !(store_ok && buf_full)) begin
                    in_ready = 1'b1;
                    crc_en   = 1'b1;
                    if (store_ok) begin
                        mem_req   = 1'b1;
                        mem_we    = 1'b1;
                        mem_addr  = byte_addr;
                        mem_be    = 4'b0001 << byte_addr[1:0];
                        mem_wdata = {4{in_data}};
                    end
                end
            end
            S_WB: begin
                mem_req        = 1'b1;
                mem_we         = 1'b1;
                mem_wdata      = wb_word;
                evt_set.frame  = wb_last;
                evt_set.buffer = !wb_last;
            end
            S_DRAIN: in_ready = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE;
            active <= 1'b0; probe_pend <= 1'b0; phase_crc <= 1'b0;
            wb_last <= 1'b0; trunc <= 1'b0;
            cur <= '0; buf_base <= '0; desc_w0 <= '0; crc_fin <= '0; crc_idx <= '0;
            buf_cnt <= '0; data_cnt <= '0; tot_cnt <= '0;
        end else begin
            if (ring_wr) cur <= {reg_wdata[AW-1:3], 3'b000};
            if (arm_wr && !active) probe_pend <= 1'b1;
            case (st)
                S_IDLE: begin
                    if (probe_pend) begin
                        probe_pend <= 1'b0;
                        st <= S_PRB0;
                    end else if (active && in_valid) begin
                        data_cnt <= '0; tot_cnt <= '0;
                        phase_crc <= 1'b0; trunc <= 1'b0;
                        st <= S_RD0;
                    end
                end
                S_RD0: st <= S_RD1;
                S_RD1: begin
                    desc_w0 <= mem_rdata;
                    st <= S_RD2;
                end
                S_RD2: begin
                    buf_base <= mem_rdata[AW-1:0];
                    buf_cnt  <= '0;
                    if (desc_w0[F_EMPTY]) st <= S_FILL;
                    else                  st <= phase_crc ? S_PRB0 : S_DRAIN;
                end
                S_FILL: begin
                    if (phase_crc) begin
                        if (buf_full) begin
                            wb_last <= 1'b0;
                            st <= S_WB;
                        end else begin
                            buf_cnt <= buf_cnt + 1'b1;
                            tot_cnt <= tot_cnt + 1'b1;
                            crc_idx <= crc_idx + 1'b1;
                            if (crc_idx == 2'd3) begin
                                wb_last <= 1'b1;
                                st <= S_WB;
                            end
                        end
                    end else if (in_valid) begin
                        if (store_ok && buf_full) begin
                            wb_last <= 1'b0;
                            st <= S_WB;
                        end else begin
                            if (store_ok) begin
                                buf_cnt  <= buf_cnt + 1'b1;
                                data_cnt <= data_cnt + 1'b1;
                                tot_cnt  <= tot_cnt + 1'b1;
                            end else begin
                                trunc <= 1'b1;
                            end
                            if (in_last) begin
                                phase_crc <= 1'b1;
                                crc_idx   <= '0;
                                crc_fin   <= ~crc_nx;
                            end
                        end
                    end
                end
                S_WB: begin
                    cur <= desc_w0[F_WRAP] ? ring_base : cur + AW'(8);
                    st  <= wb_last ? S_PRB0 : S_RD0;
                end
                S_DRAIN: if (in_valid && in_last) st <= S_PRB0;
                S_PRB0: st <= S_PRB1;
                S_PRB1: begin
                    active <= mem_rdata[F_EMPTY];
                    st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rx_bd_scatter_chk.sv
module rx_bd_scatter_chk import rxs_pkg::*; #(
    parameter int MAXF = 2032
) (
    input logic          clk,
    input logic          rst,
    input logic          in_ready,
    input logic          active,
    input logic          mem_req,
    input logic          mem_we,
    input logic [3:0]    mem_be,
    input logic [31:0]   mem_wdata,
    input logic [LW-1:0] buf_cnt,
    input logic [LW-1:0] mrbr,
    input logic [LW-1:0] tot_cnt,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [1:0]    evt_set,
    input logic [1:0]    events
);
    // R8
    ready_needs_active_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> active);

    // R1
    stored_size_cap_chk: assert property (@(posedge clk) disable iff (rst)
        tot_cnt <= LW'(MAXF));

    // R3
    buffer_no_overfill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_be != 4'hF) |-> (buf_cnt < mrbr && $countones(mem_be) == 1));

    // R5
    writeback_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_be == 4'hF) |-> !mem_wdata[F_EMPTY]);

    // R9
    event_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == RG_EVT && reg_wdata[0] && !evt_set[0]) |=> !events[0]);
endmodule

bind rx_bd_scatter rx_bd_scatter_chk #(.MAXF(MAX_FRAME)) u_chk (
    .clk(clk), .rst(rst), .in_ready(in_ready), .active(active),
    .mem_req(mem_req), .mem_we(mem_we), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .buf_cnt(buf_cnt), .mrbr(mrbr), .tot_cnt(tot_cnt),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .evt_set(evt_set), .events(events)
);

// File: tb/rx_bd_scatter_test.sv
module rx_bd_scatter_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 12;
    localparam int MAXF = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_last = 1'b0, in_ready;
    logic [7:0] in_data = '0;
    logic mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [3:0] mem_be;
    logic [31:0] mem_wdata, mem_rdata;
    logic reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic irq;

    int nchk = 0, nerr = 0;
    int nring, mcur, mrbr_m, ulim_m;
    bit sh_empty[8];
    bit sh_wrap[8];

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_bd_scatter #(.AW(AW), .MAX_FRAME(MAXF)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    logic [7:0] mem [0:(1<<AW)-1];
    logic [31:0] rd_q = '0;
    assign mem_rdata = rd_q;

    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                for (int l = 0; l < 4; l++)
                    if (mem_be[l]) mem[{mem_addr[AW-1:2], 2'(l)}] <= mem_wdata[8*l +: 8];
            end else begin
                rd_q <= {mem[{mem_addr[AW-1:2], 2'd3}], mem[{mem_addr[AW-1:2], 2'd2}],
                         mem[{mem_addr[AW-1:2], 2'd1}], mem[{mem_addr[AW-1:2], 2'd0}]};
            end
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = idx; reg_wdata = val;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] idx, output logic [31:0] val);
        @(negedge clk);
        reg_addr = idx;
        #1 val = reg_rdata;
    endtask

    task automatic put_word(input int a, input logic [31:0] v);
        for (int k = 0; k < 4; k++) mem[a + k] = v[8*k +: 8];
    endtask

    function automatic logic [31:0] get_word(input int a);
        return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
    endfunction

    function automatic logic [31:0] ref_crc(input logic [7:0] q[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (q[i]) begin
            c = c ^ {24'h0, q[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic fresh_ring(input int n);
        for (int i = 0; i < n; i++) begin
            sh_empty[i] = 1'b1;
            sh_wrap[i]  = (i == n - 1);
            put_word(8*i, 32'h8000_0000 | (sh_wrap[i] ? 32'h2000_0000 : 32'h0));
            put_word(8*i + 4, 32'h400 + 32'h80 * i);
        end
        nring = n;
        mcur = 0;
        wr_reg(3'd4, 32'h0);
        wr_reg(3'd2, 32'h1);
        repeat (8) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] fb[$]);
        int to;
        for (int i = 0; i < fb.size(); i++) begin
            @(negedge clk);
            in_valid = 1'b1; in_data = fb[i]; in_last = (i == fb.size() - 1);
            #1;
            to = 0;
            while (!in_ready && to < 500) begin
                @(negedge clk); #1; to++;
            end
            if (to >= 500) check(1'b0, "R8 stream stall", 32'(to), 32'h0);
        end
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
        repeat (40) @(negedge clk);
    endtask

    task automatic run_frame(input int len, input int seed, input string tag);
        logic [7:0] fb[$];
        logic [7:0] st[$];
        logic [31:0] crc, w, expw, rv;
        int ndata, size, pos, d, cnt, nbuf, bad;
        bit trunc, lg, done;
        wr_reg(3'd0, 32'h3);
        for (int i = 0; i < len; i++) fb.push_back(8'(seed + 7*i));
        crc   = ref_crc(fb);
        trunc = (len + 4 > MAXF);
        ndata = trunc ? MAXF - 4 : len;
        size  = ndata + 4;
        lg    = trunc || (size > ulim_m);
        for (int i = 0; i < ndata; i++) st.push_back(fb[i]);
        for (int i = 3; i >= 0; i--) st.push_back(crc[8*i +: 8]);
        send_frame(fb);
        pos = 0; d = mcur; nbuf = 0; done = 1'b0;
        while (pos < size) begin
            if (!sh_empty[d]) break;
            cnt = (size - pos < mrbr_m) ? size - pos : mrbr_m;
            bad = 0;
            for (int k = 0; k < cnt; k++)
                if (mem[32'h400 + 32'h80*d + k] !== st[pos + k]) bad++;
            check(bad == 0, {tag, " R4 stored bytes"}, 32'(bad), 32'h0);
            pos += cnt;
            w = get_word(8*d);
            expw = (sh_wrap[d] ? 32'h2000_0000 : 32'h0) | 32'(cnt);
            if (pos == size) expw |= 32'h0800_0000 | (trunc ? 32'h0001_0000 : 32'h0)
                                                   | (lg ? 32'h0020_0000 : 32'h0);
            check(w === expw, {tag, " R5 descriptor word"}, w, expw);
            sh_empty[d] = 1'b0;
            if (pos == size) done = 1'b1; else nbuf++;
            d = sh_wrap[d] ? 0 : d + 1;
        end
        mcur = d;
        rd_reg(3'd0, rv);
        check(rv === {30'h0, nbuf > 0, done}, {tag, " R5 events"}, rv, {30'h0, nbuf > 0, done});
        rd_reg(3'd2, rv);
        check(rv === 32'(sh_empty[mcur]), {tag, " R8 rearm"}, rv, 32'(sh_empty[mcur]));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nchk++; nerr++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        bit seen;
        ulim_m = 32'h05EE;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state
        rd_reg(3'd0, rv); check(rv === 0, "R9 events reset", rv, 0);
        rd_reg(3'd3, rv); check(rv === 32'h05EE0001, "R2 control reset", rv, 32'h05EE0001);
        rd_reg(3'd5, rv); check(rv === 0, "R3 bufsize reset", rv, 0);
        rd_reg(3'd2, rv); check(rv === 0, "R8 active reset", rv, 0);
        check(irq === 1'b0, "R9 irq reset", 32'(irq), 0);

        // register masks
        wr_reg(3'd5, 32'hFFFF_FFFF);
        rd_reg(3'd5, rv); check(rv === 32'h3FF0, "R3 bufsize mask", rv, 32'h3FF0);
        wr_reg(3'd3, 32'hFFFF_FFFF);
        rd_reg(3'd3, rv); check(rv === 32'h07FF003F, "R2 control mask", rv, 32'h07FF003F);
        wr_reg(3'd3, 32'h05EE0001);
        wr_reg(3'd5, 32'd16); mrbr_m = 16;

        // refused while inactive
        @(negedge clk); in_valid = 1'b1; in_data = 8'h55; seen = 1'b0;
        for (int i = 0; i < 10; i++) begin @(negedge clk); #1 if (in_ready) seen = 1'b1; end
        check(!seen, "R8 refused while inactive", 32'(seen), 0);
        in_valid = 1'b0;

        // split frames, straddling CRC, wrap and re-arm
        fresh_ring(4);
        rd_reg(3'd2, rv); check(rv === 1, "R8 arm probe", rv, 1);
        run_frame(20, 3, "R3 split");
        run_frame(14, 9, "R4 straddle R6 wrap");
        sh_empty[0] = 1'b1;
        put_word(0, 32'h8000_0000);
        wr_reg(3'd2, 32'h1);
        repeat (8) @(negedge clk);
        rd_reg(3'd2, rv); check(rv === 1, "R8 re-probe", rv, 1);
        run_frame(12, 21, "R3 exact fit R6");

        // user limit
        wr_reg(3'd3, (32'd20 << 16) | 32'h1); ulim_m = 20;
        fresh_ring(4);
        run_frame(16, 40, "R2 at limit");
        run_frame(20, 41, "R2 over limit");
        wr_reg(3'd3, 32'h05EE0001); ulim_m = 32'h05EE;

        // hard limit truncation
        wr_reg(3'd5, 32'd32); mrbr_m = 32;
        fresh_ring(4);
        run_frame(70, 77, "R1 truncate");

        // busy descriptor mid-frame
        wr_reg(3'd5, 32'd16); mrbr_m = 16;
        fresh_ring(4);
        put_word(8, 32'h0); sh_empty[1] = 1'b0;
        run_frame(30, 5, "R7 drop");
        check(get_word(8) === 32'h0, "R7 busy descriptor untouched", get_word(8), 0);

        // interrupt and write-one-to-clear
        fresh_ring(4);
        wr_reg(3'd1, 32'h1);
        run_frame(10, 60, "R9 irq");
        @(negedge clk); check(irq === 1'b1, "R9 irq raised", 32'(irq), 1);
        wr_reg(3'd0, 32'h0);
        @(negedge clk); check(irq === 1'b1, "R9 zero write keeps", 32'(irq), 1);
        wr_reg(3'd0, 32'h1);
        @(negedge clk); check(irq === 1'b0, "R9 w1c clears", 32'(irq), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule